// File: doc/BRIEF.md
# Trigger-Driven Single Move Engine

This block copies one data item from a programmable source address to a programmable destination address each time an external trigger line pulses. The processor takes no part in the copy. The trigger goes through a two-stage synchronizer and an edge detector, so a pulse of any length counts once. The block then drives a simple synchronous bus master port. It reads the source first and writes the destination second. Each bus phase holds its request until the target acknowledges it.

Software loads a move budget, the two addresses, one address-advance enable for each side, and a byte/word size select. Each serviced trigger takes one unit from the budget. The move that spends the last unit raises the interrupt flag when its write completes. A trigger that finds the budget already empty performs no move and becomes an interrupt request within three clock edges. A trigger that arrives while a move is in flight is held and serviced as soon as that move completes. The interrupt flag stays high until software clears it.

Top module: `sig_move_ctrl`

## Requirements
- R1: After reset, irq_o and bus_req_o are 0 and every register index (0 to 4) reads back 0.
- R2: One rising edge of trig_i causes exactly one move, however many cycles trig_i stays high.
- R3: A serviced trigger with a non-zero budget first makes a read request (bus_we_o=0) at the source address. After that read is acknowledged, it makes a write request (bus_we_o=1) at the destination address. The budget at register index 0 drops by one.
- R4: Control register index 3, bit 2, selects word (1) or byte (0). In a byte move, bus_word_o is 0 and bus_wdata_o carries the low byte that was read, with bits 15:8 at zero. In a word move, bus_word_o is 1 and all 16 bits are copied.
- R5: Control bits 0 and 1 enable address advance for the source (index 1) and the destination (index 2). When its enable is set, an address advances by 1 after a byte move or by 2 after a word move. When its enable is clear, the address is unchanged.
- R6: While a request is not acknowledged, bus_req_o stays high and bus_addr_o and bus_we_o keep their values.
- R7: The move that takes the budget from 1 to 0 sets irq_o on the clock edge after its write acknowledge.
- R8: A trigger that finds the budget at 0 makes no bus request and leaves the budget at 0. It sets irq_o on the second clock edge after the first edge that samples trig_i high.
- R9: A trigger that arrives while a move is in progress is held pending and is serviced after that move. It is not dropped.
- R10: Writing register index 4 with bit 0 set clears irq_o. Writing index 4 with bit 0 clear leaves irq_o unchanged. If an interrupt is set in the same cycle as a clear, the set wins.
- R11: Indices 0 to 3 read back the budget, the source address, the destination address and the control bits. Index 4 reads the interrupt flag in bit 0.
- R12: Writing a non-zero budget after it has run out makes triggers perform moves again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | External trigger, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | AW | Register write data |
| cfg_rdata_o | output | AW | Register read data for cfg_addr_i |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 = write phase, 0 = read phase |
| bus_word_o | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |
| bus_ack_i | input | 1 | Bus acknowledge, ends the current phase |
| irq_o | output | 1 | Interrupt request flag |

## Verification
Setting the interrupt flag and clearing it by software can land in the same cycle. Setting happens when a trigger meets an empty budget or when the final move completes. To provoke the clash, the bench pulses trig_i with the budget at zero and times a status write with bit 0 set so that it falls in the same cycle. Based on the synchronizer latency, that is the second clock edge after the trigger is first sampled. Immediately after that edge the bench expects irq_o to be high. A separate clear that arrives later must then drop it.

// File: rtl/mv_pkg.sv
package mv_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned BW  = 8;
  localparam int unsigned RIW = 3;

  localparam logic [RIW-1:0] REG_CNT = 3'd0;
  localparam logic [RIW-1:0] REG_SRC = 3'd1;
  localparam logic [RIW-1:0] REG_DST = 3'd2;
  localparam logic [RIW-1:0] REG_CTL = 3'd3;
  localparam logic [RIW-1:0] REG_STS = 3'd4;

  localparam int unsigned CTL_SRC_INC = 0;
  localparam int unsigned CTL_DST_INC = 1;
  localparam int unsigned CTL_WORD    = 2;
  localparam int unsigned CTL_W       = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} mv_state_e;
endpackage

// File: rtl/mv_trig_sync.sv
module mv_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  // STAGES sync flops plus one history flop for edge detect
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mv_addr_ctr.sv
module mv_addr_ctr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          adv_i,
  input  logic          inc_en_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] step;

  assign step = word_i ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (ld_i)              addr_q <= ld_val_i;  // software wins
    else if (adv_i && inc_en_i) addr_q <= addr_q + step;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/mv_regs.sv
module mv_regs
  import mv_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [RIW-1:0] cfg_addr_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  output logic [AW-1:0]  cfg_rdata_o,
  input  logic           dec_i,
  input  logic           adv_i,
  input  logic           step_word_i,
  input  logic           irq_set_i,
  output logic [CW-1:0]  cnt_o,
  output logic [AW-1:0]  src_o,
  output logic [AW-1:0]  dst_o,
  output logic           word_o,
  output logic           irq_o
);
  logic [CW-1:0]    cnt_q;
  logic [CTL_W-1:0] ctl_q;
  logic             irq_q;
  logic             irq_clr;
  logic [AW-1:0]    addr_w [2];

  assign irq_clr = cfg_we_i && (cfg_addr_i == REG_STS) && cfg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_addr_i == REG_CNT)  cnt_q <= cfg_wdata_i[CW-1:0];
      else if (dec_i && cnt_q != '0)          cnt_q <= cnt_q - CW'(1);
      if (cfg_we_i && cfg_addr_i == REG_CTL)  ctl_q <= cfg_wdata_i[CTL_W-1:0];
      if (irq_set_i)                          irq_q <= 1'b1;  // set beats clear
      else if (irq_clr)                       irq_q <= 1'b0;
    end
  end

  // index 0 = source, 1 = destination; ctl bit gi enables its advance
  for (genvar gi = 0; gi < 2; gi++) begin : g_addr
    localparam logic [RIW-1:0] SEL = (gi == 0) ? REG_SRC : REG_DST;
    mv_addr_ctr #(.AW(AW)) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (cfg_we_i && cfg_addr_i == SEL),
      .ld_val_i (cfg_wdata_i),
      .adv_i    (adv_i),
      .inc_en_i (ctl_q[gi]),
      .word_i   (step_word_i),
      .addr_o   (addr_w[gi])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_addr_i)
      REG_CNT: cfg_rdata_o = AW'(cnt_q);
      REG_SRC: cfg_rdata_o = addr_w[0];
      REG_DST: cfg_rdata_o = addr_w[1];
      REG_CTL: cfg_rdata_o = AW'(ctl_q);
      REG_STS: cfg_rdata_o = AW'(irq_q);
      default: cfg_rdata_o = '0;
    endcase
  end

  assign cnt_o  = cnt_q;
  assign src_o  = addr_w[0];
  assign dst_o  = addr_w[1];
  assign word_o = ctl_q[CTL_WORD];
  assign irq_o  = irq_q;
endmodule

// File: rtl/mv_seq.sv
module mv_seq
  import mv_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          word_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic          dec_o,
  output logic          adv_o,
  output logic          step_word_o,
  output logic          irq_set_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_word_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i
);
  mv_state_e     st_q, st_d;
  logic          pend_q, pend_d;
  logic          last_q, word_q;
  logic [DW-1:0] data_q;
  logic          busy, evt, start, empty_hit, wr_done;

  assign busy      = (st_q != ST_IDLE);
  assign evt       = rise_i | pend_q;
  assign start     = !busy && evt && (cnt_i != '0);
  assign empty_hit = !busy && evt && (cnt_i == '0);
  assign wr_done   = (st_q == ST_WR) && bus_ack_i;

  // one-deep pending slot; a new edge in the cycle the slot drains refills it
  assign pend_d = busy ? (pend_q | rise_i) : (pend_q & rise_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)     st_d = ST_RD;
      ST_RD:   if (bus_ack_i) st_d = ST_WR;
      ST_WR:   if (bus_ack_i) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      last_q <= 1'b0;
      word_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (start) begin
        last_q <= (cnt_i == CW'(1));
        word_q <= word_i;
      end
      if (st_q == ST_RD && bus_ack_i)
        data_q <= word_q ? bus_rdata_i : {{(DW-BW){1'b0}}, bus_rdata_i[BW-1:0]};
    end
  end

  assign dec_o       = start;
  assign adv_o       = wr_done;
  assign step_word_o = word_q;
  assign irq_set_o   = empty_hit | (wr_done & last_q);

  assign bus_req_o   = busy;
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_word_o  = word_q;
  assign bus_addr_o  = (st_q == ST_WR) ? dst_i : src_i;
  assign bus_wdata_o = data_q;
endmodule

// File: rtl/sig_move_ctrl.sv
module sig_move_ctrl
  import mv_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned CW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           trig_i,
  input  logic           cfg_we_i,
  input  logic [2:0]     cfg_addr_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  output logic [AW-1:0]  cfg_rdata_o,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic           bus_word_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [15:0]    bus_wdata_o,
  input  logic [15:0]    bus_rdata_i,
  input  logic           bus_ack_i,
  output logic           irq_o
);
  logic          rise;
  logic          dec, adv, step_word, irq_set, word;
  logic [CW-1:0] cnt;
  logic [AW-1:0] src, dst;

  mv_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  mv_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .dec_i       (dec),
    .adv_i       (adv),
    .step_word_i (step_word),
    .irq_set_i   (irq_set),
    .cnt_o       (cnt),
    .src_o       (src),
    .dst_o       (dst),
    .word_o      (word),
    .irq_o       (irq_o)
  );

  mv_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .cnt_i       (cnt),
    .word_i      (word),
    .src_i       (src),
    .dst_i       (dst),
    .dec_o       (dec),
    .adv_o       (adv),
    .step_word_o (step_word),
    .irq_set_o   (irq_set),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_word_o  (bus_word_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ack_i   (bus_ack_i)
  );
endmodule

// File: rtl/sig_move_ctrl_chk.sv
module sig_move_ctrl_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [2:0]    cfg_addr_i,
  input logic [AW-1:0] cfg_wdata_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_word_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [15:0]   bus_wdata_o,
  input logic          bus_ack_i,
  input logic          irq_o
);
  // R6
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  // R3
  rd_before_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_req_o && !bus_we_o && bus_ack_i));

  // R4
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && !bus_word_o) |-> (bus_wdata_o[15:8] == 8'h00));

  // R10
  irq_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(cfg_we_i && cfg_addr_i == 3'd4 && cfg_wdata_i[0]));

  // R7 R8
  irq_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(bus_req_o && bus_we_o && bus_ack_i) || $past(!bus_req_o)));
endmodule

bind sig_move_ctrl sig_move_ctrl_chk #(.AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_word_o  (bus_word_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .irq_o       (irq_o)
);

// File: tb/sig_move_ctrl_tb_top.sv
module sig_move_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        bus_req, bus_we, bus_word, bus_ack;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        irq;
  logic        ack_en = 1'b1;

  logic [7:0]  mem [256];
  int          n_wr = 0;
  int          n_req = 0;
  logic [15:0] last_wdata = '0;
  int          nchk = 0;
  int          nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  sig_move_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_word_o(bus_word),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .irq_o(irq)
  );

  assign bus_ack   = bus_req & ack_en;
  assign bus_rdata = {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]};

  function automatic logic [7:0] f(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (bus_req) n_req <= n_req + 1;
    if (bus_req && bus_we && bus_ack) begin
      n_wr <= n_wr + 1;
      last_wdata <= bus_wdata;
      mem[bus_addr[7:0]] <= bus_wdata[7:0];
      if (bus_word) mem[bus_addr[7:0] + 8'd1] <= bus_wdata[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [15:0] v);
    @(negedge clk); cfg_addr = idx; #1 v = cfg_rdata;
  endtask

  task automatic pulse(input int len);
    @(negedge clk); trig = 1'b1;
    repeat (len) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", irq, 0);
    chk("R1 req", bus_req, 0);
    for (int i = 0; i < 5; i++) begin
      rd_reg(3'(i), v); chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr_reg(3'd1, 16'h0010); wr_reg(3'd2, 16'h0080);
    wr_reg(3'd3, 16'h0007); wr_reg(3'd0, 16'h0005);
    rd_reg(3'd0, v); chk("R11 cnt", v, 5);
    rd_reg(3'd1, v); chk("R11 src", v, 16'h0010);
    rd_reg(3'd2, v); chk("R11 dst", v, 16'h0080);
    rd_reg(3'd3, v); chk("R11 ctl", v, 16'h0007);
  endtask

  task automatic t_word();
    logic [15:0] v;
    int w0 = n_wr;
    pulse(1); idle(10);
    chk("R3 one write", n_wr - w0, 1);
    chk("R4 word data", {mem[8'h81], mem[8'h80]}, {f(8'h11), f(8'h10)});
    rd_reg(3'd0, v); chk("R3 cnt dec", v, 4);
    rd_reg(3'd1, v); chk("R5 src +2", v, 16'h0012);
    rd_reg(3'd2, v); chk("R5 dst +2", v, 16'h0082);
  endtask

  task automatic t_long();
    logic [15:0] v;
    int w0 = n_wr;
    pulse(8); idle(10);
    chk("R2 long pulse one move", n_wr - w0, 1);
    chk("R2 data", {mem[8'h83], mem[8'h82]}, {f(8'h13), f(8'h12)});
    rd_reg(3'd0, v); chk("R2 cnt", v, 3);
  endtask

  task automatic t_byte();
    logic [15:0] v;
    wr_reg(3'd3, 16'h0001); wr_reg(3'd1, 16'h0020);
    wr_reg(3'd2, 16'h0090); wr_reg(3'd0, 16'd10);
    pulse(1); idle(10); pulse(1); idle(10);
    chk("R4 byte dst", mem[8'h90], f(8'h21));
    chk("R4 byte neighbour kept", mem[8'h91], f(8'h91));
    chk("R4 byte wdata", last_wdata, {8'h00, f(8'h21)});
    rd_reg(3'd1, v); chk("R5 src +1", v, 16'h0022);
    rd_reg(3'd2, v); chk("R5 dst held", v, 16'h0090);
    rd_reg(3'd0, v); chk("R3 cnt byte", v, 8);
  endtask

  task automatic t_wait_pend();
    logic [15:0] v;
    int w0;
    wr_reg(3'd3, 16'h0007); wr_reg(3'd1, 16'h0030);
    wr_reg(3'd2, 16'h00A0); wr_reg(3'd0, 16'd10);
    w0 = n_wr;
    ack_en = 1'b0;
    pulse(1); idle(6);
    chk("R6 req held", bus_req, 1);
    chk("R6 read phase", bus_we, 0);
    chk("R6 addr src", bus_addr, 16'h0030);
    pulse(1); idle(6);
    chk("R6 still held", bus_addr, 16'h0030);
    chk("R6 no write", n_wr - w0, 0);
    ack_en = 1'b1; idle(14);
    chk("R9 pending serviced", n_wr - w0, 2);
    chk("R9 data2", {mem[8'hA3], mem[8'hA2]}, {f(8'h33), f(8'h32)});
    rd_reg(3'd0, v); chk("R9 cnt", v, 8);
  endtask

  task automatic t_last();
    int w0 = n_wr;
    wr_reg(3'd0, 16'd1);
    pulse(1);
    chk("R7 irq before", irq, 0);
    idle(10);
    chk("R7 move done", n_wr - w0, 1);
    chk("R7 irq set", irq, 1);
  endtask

  task automatic t_clear();
    wr_reg(3'd4, 16'h0000); idle(1);
    chk("R10 zero write keeps", irq, 1);
    wr_reg(3'd4, 16'h0001); idle(1);
    chk("R10 clear", irq, 0);
  endtask

  task automatic t_empty();
    logic [15:0] v;
    int r0 = n_req;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk("R8 irq after 1st edge", irq, 0);
    @(negedge clk); chk("R8 irq after 2nd edge", irq, 0);
    @(negedge clk); chk("R8 irq after 3rd edge", irq, 1);
    idle(6);
    chk("R8 no request", n_req - r0, 0);
    rd_reg(3'd0, v); chk("R8 cnt stays 0", v, 0);
    rd_reg(3'd4, v); chk("R11 status", v, 1);
  endtask

  task automatic t_collide();
    wr_reg(3'd4, 16'h0001); idle(1);
    chk("R10 pre clear", irq, 0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 16'h0001;
    @(negedge clk); cfg_we = 1'b0;
    chk("R10 set beats clear", irq, 1);
    wr_reg(3'd4, 16'h0001); idle(1);
    chk("R10 later clear", irq, 0);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    int w0 = n_wr;
    wr_reg(3'd0, 16'd2);
    pulse(1); idle(10);
    chk("R12 move after reload", n_wr - w0, 1);
    rd_reg(3'd0, v); chk("R12 cnt", v, 1);
    chk("R12 irq low", irq, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = f(i);
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_word();
    t_long();
    t_byte();
    t_wait_pend();
    t_last();
    t_clear();
    t_empty();
    t_collide();
    t_reload();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule